// File: doc/BRIEF.md
# Per-Block Write Lock Array for a 16 MB Serial Flash

This block holds the write-protection state of a 16 MB serial flash that supports a protection scheme based on per-unit lock bits. A command front end hands it decoded commands, each with an opcode byte and a 24-bit address. The opcodes cover a one-way selection of the protection scheme, locking or unlocking a single unit, locking or unlocking every unit at once, and reading the lock state of one unit. The front end also asks the block whether a program or erase at a given address may proceed. The block answers one cycle later with a grant or a fail.

Two protection schemes are exclusive. Before the scheme is selected, protection comes from the range bits. The block does not decode those bits. It sees their verdict for the requested address on `range_prot_i`. Once the per-unit scheme is selected, only the lock bits count, and nothing can return the block to range-bit protection. The lock units have mixed granularity:

- The lowest 64 KB and the highest 64 KB of the address space are each split into sixteen 4 KB sectors.
- Each of the other 254 regions is one 64 KB block.

That gives 286 lock bits in total. Every lock bit reads as locked after reset.

The scheme-select bit is non-volatile. The block shows it on `mode_o` so a non-volatile store can hold it. The block reloads it from `mode_nv_i` while reset is asserted.

The controller is a state machine that can accept a new request on every cycle. Each request sets the state for the next cycle:

| State | Entered when, in the previous cycle | Action in this cycle |
|---|---|---|
| ST_IDLE | nothing was accepted, or a command was refused | no action |
| ST_LOCK1 | 36h was accepted | locks one unit |
| ST_UNLOCK1 | 39h was accepted | unlocks one unit |
| ST_LOCKALL | 7Eh was accepted | locks every unit |
| ST_UNLOCKALL | 98h was accepted | unlocks every unit |
| ST_SELECT | 68h was accepted | selects the per-unit scheme for good and locks every unit |
| ST_STATUS | 3Ch was accepted | returns the lock bit of the addressed unit |
| ST_PECHK | a program/erase check was accepted | returns grant or fail |

From any state, the next state follows only from that cycle's inputs. A refused command or an idle cycle leads to ST_IDLE.

Top module: `flash_blk_lock`

## Requirements
- R1: While `rst_n` is low, the scheme bit loads from `mode_nv_i` and all 286 lock bits become locked. After reset, `pe_done_o`, `rd_valid_o` and `wel_clr_o` are low.
- R2: While `mode_o` is 0 (range-bit scheme), a program/erase check fails exactly when `range_prot_i` was high with the request. The lock bits have no effect on the result.
- R3: Opcode 68h with `wel_i` high sets `mode_o` to 1. No command clears it. Only a reset with `mode_nv_i` low returns it to 0.
- R4: While `mode_o` is 1, a program/erase check fails exactly when the lock bit of the addressed unit is 1. `range_prot_i` has no effect on the result.
- R5: Address bits [23:16] select the unit. A value of 00h means a bottom 4 KB sector chosen by bits [15:12]. A value of FFh means a top 4 KB sector chosen by bits [15:12]. Any other value means one 64 KB block.
- R6: Opcode 36h locks the unit that contains `cmd_addr_i`. Opcode 39h unlocks it. No other unit changes.
- R7: Opcode 7Eh locks every unit. Opcode 98h unlocks every unit.
- R8: Opcode 3Ch makes `rd_valid_o` high for one cycle in the next cycle, with `rd_locked_o` showing the addressed unit's lock bit (1 means locked).
- R9: Opcode 68h needs `wel_i` high. Opcodes 36h, 39h, 7Eh and 98h need both `wel_i` and `mode_o` high. An accepted command pulses `wel_clr_o` in the next cycle. A refused command, or any other opcode, changes nothing and leaves `wel_clr_o` low.
- R10: A check with `pe_req_i` makes `pe_done_o` high for one cycle in the next cycle. In that cycle exactly one of `pe_grant_o` and `pe_fail_o` is high. Outside such a cycle both are low.
- R11: When `cmd_valid_i` and `pe_req_i` are high in the same cycle, the command is served and the program/erase check is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-up or software reset) |
| mode_nv_i | input | 1 | Scheme bit from the non-volatile store, loaded during reset |
| cmd_valid_i | input | 1 | Decoded command present |
| cmd_op_i | input | 8 | Command opcode |
| cmd_addr_i | input | 24 | Command address |
| wel_i | input | 1 | Write-enable latch is set |
| pe_req_i | input | 1 | Program/erase permission request |
| pe_addr_i | input | 24 | Program/erase target address |
| range_prot_i | input | 1 | Range-bit verdict for `pe_addr_i` (1 means protected) |
| wel_clr_o | output | 1 | Clear the write-enable latch |
| rd_valid_o | output | 1 | Lock status answer valid |
| rd_locked_o | output | 1 | Lock status answer (1 means locked) |
| pe_done_o | output | 1 | Program/erase answer valid |
| pe_grant_o | output | 1 | Program/erase allowed |
| pe_fail_o | output | 1 | Program/erase rejected (one-cycle flag) |
| mode_o | output | 1 | Per-unit scheme selected |

## Verification
The in-line assertions check properties that hold on every cycle:

- the scheme bit never falls outside reset;
- grant and fail are exclusive and appear only when an answer is due;
- every answer, latch clear and status response traces back to an accepted request one cycle earlier;
- a global lock leaves every bit set.

Only the bench scenarios can show the mapping of addresses to units, because that is a relation between stored data and later answers, not a per-cycle property. The bench scenarios also cover:

- which single bit a command touches;
- the neighbours of the top and bottom sector regions;
- the refusal of gated commands;
- the reload of the scheme bit across a reset.

// File: rtl/flk_pkg.sv
package flk_pkg;
    localparam logic [7:0] OP_SELECT    = 8'h68;
    localparam logic [7:0] OP_LOCK1     = 8'h36;
    localparam logic [7:0] OP_UNLOCK1   = 8'h39;
    localparam logic [7:0] OP_LOCKALL   = 8'h7E;
    localparam logic [7:0] OP_UNLOCKALL = 8'h98;
    localparam logic [7:0] OP_STATUS    = 8'h3C;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOCK1,
        ST_UNLOCK1,
        ST_LOCKALL,
        ST_UNLOCKALL,
        ST_SELECT,
        ST_STATUS,
        ST_PECHK
    } flk_state_e;
endpackage

// File: rtl/flk_addr_map.sv
module flk_addr_map #(
    parameter int ADDR_W    = 24,
    parameter int BLK_SHIFT = 16,
    parameter int SEC_SHIFT = 12,
    parameter int IDX_W     = 9
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx
);
    localparam int BLK_W    = ADDR_W - BLK_SHIFT;
    localparam int SEC_W    = BLK_SHIFT - SEC_SHIFT;
    localparam int NSEC     = 1 << SEC_W;
    localparam int NBLK     = 1 << BLK_W;
    localparam int TOP_BASE = NSEC + NBLK - 2;

    logic [BLK_W-1:0] blk;
    logic [SEC_W-1:0] sec;

    assign blk = addr[ADDR_W-1:BLK_SHIFT];
    assign sec = addr[BLK_SHIFT-1:SEC_SHIFT];

    // Bottom sectors first, then middle blocks, then top sectors.
    always_comb begin
        if (blk == '0)
            idx = IDX_W'(sec);
        else if (&blk)
            idx = IDX_W'(TOP_BASE) + IDX_W'(sec);
        else
            idx = IDX_W'(NSEC - 1) + IDX_W'(blk);
    end
endmodule

// File: rtl/flk_lock_bank.sv
module flk_lock_bank #(
    parameter int NLOCK = 286,
    parameter int IDX_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_all,
    input  logic             clr_all,
    input  logic             wr_en,
    input  logic             wr_val,
    input  logic [IDX_W-1:0] idx,
    output logic             rd_bit
);
    logic [NLOCK-1:0] lock_q;

    for (genvar i = 0; i < NLOCK; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                lock_q[i] <= 1'b1;
            else if (set_all)
                lock_q[i] <= 1'b1;
            else if (clr_all)
                lock_q[i] <= 1'b0;
            else if (wr_en && (idx == IDX_W'(i)))
                lock_q[i] <= wr_val;
        end
    end

    always_comb begin
        rd_bit = 1'b1;
        if (idx < IDX_W'(NLOCK))
            rd_bit = lock_q[idx];
    end

    // R7
    all_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_all |=> (&lock_q));
endmodule

// File: rtl/flk_ctrl.sv
module flk_ctrl
    import flk_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_nv_i,
    input  logic              cmd_valid_i,
    input  logic [7:0]        cmd_op_i,
    input  logic [ADDR_W-1:0] cmd_addr_i,
    input  logic              wel_i,
    input  logic              pe_req_i,
    input  logic [ADDR_W-1:0] pe_addr_i,
    input  logic              range_prot_i,
    input  logic              lock_bit_i,
    output logic [ADDR_W-1:0] addr_q_o,
    output logic              set_all_o,
    output logic              clr_all_o,
    output logic              wr_en_o,
    output logic              wr_val_o,
    output logic              wel_clr_o,
    output logic              rd_valid_o,
    output logic              rd_locked_o,
    output logic              pe_done_o,
    output logic              pe_grant_o,
    output logic              pe_fail_o,
    output logic              mode_o
);
    flk_state_e        state_q, state_d;
    logic              mode_q;
    logic              rprot_q;
    logic [ADDR_W-1:0] addr_q;
    logic              blocked;

    // Next state: one request is accepted per cycle; commands win over checks.
    always_comb begin
        state_d = ST_IDLE;
        if (cmd_valid_i) begin
            unique case (cmd_op_i)
                OP_SELECT:    state_d = wel_i ? ST_SELECT : ST_IDLE;
                OP_LOCK1:     state_d = (wel_i && mode_q) ? ST_LOCK1 : ST_IDLE;
                OP_UNLOCK1:   state_d = (wel_i && mode_q) ? ST_UNLOCK1 : ST_IDLE;
                OP_LOCKALL:   state_d = (wel_i && mode_q) ? ST_LOCKALL : ST_IDLE;
                OP_UNLOCKALL: state_d = (wel_i && mode_q) ? ST_UNLOCKALL : ST_IDLE;
                OP_STATUS:    state_d = ST_STATUS;
                default:      state_d = ST_IDLE;
            endcase
        end else if (pe_req_i) begin
            state_d = ST_PECHK;
        end
    end

    // State, address, range verdict and scheme bit.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= mode_nv_i;
            rprot_q <= 1'b0;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_SELECT)
                mode_q <= 1'b1;
            if (cmd_valid_i) begin
                addr_q <= cmd_addr_i;
            end else if (pe_req_i) begin
                addr_q  <= pe_addr_i;
                rprot_q <= range_prot_i;
            end
        end
    end

    assign blocked = mode_q ? lock_bit_i : rprot_q;

    // Outputs per state.
    always_comb begin
        set_all_o   = 1'b0;
        clr_all_o   = 1'b0;
        wr_en_o     = 1'b0;
        wr_val_o    = 1'b0;
        wel_clr_o   = 1'b0;
        rd_valid_o  = 1'b0;
        rd_locked_o = 1'b0;
        pe_done_o   = 1'b0;
        pe_grant_o  = 1'b0;
        pe_fail_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_LOCK1: begin
                wr_en_o   = 1'b1;
                wr_val_o  = 1'b1;
                wel_clr_o = 1'b1;
            end
            ST_UNLOCK1: begin
                wr_en_o   = 1'b1;
                wel_clr_o = 1'b1;
            end
            ST_LOCKALL, ST_SELECT: begin
                set_all_o = 1'b1;
                wel_clr_o = 1'b1;
            end
            ST_UNLOCKALL: begin
                clr_all_o = 1'b1;
                wel_clr_o = 1'b1;
            end
            ST_STATUS: begin
                rd_valid_o  = 1'b1;
                rd_locked_o = lock_bit_i;
            end
            ST_PECHK: begin
                pe_done_o  = 1'b1;
                pe_grant_o = !blocked;
                pe_fail_o  = blocked;
            end
            default: ;
        endcase
    end

    assign addr_q_o = addr_q;
    assign mode_o   = mode_q;

    // R3
    mode_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q |=> mode_q);
    // R10
    pe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pe_grant_o, pe_fail_o}) && ((pe_grant_o || pe_fail_o) == pe_done_o));
    // R11
    pe_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pe_done_o |-> $past(pe_req_i && !cmd_valid_i));
    // R9
    wel_clr_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wel_clr_o |-> $past(cmd_valid_i && wel_i));
    // R8
    rd_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> $past(cmd_valid_i && (cmd_op_i == OP_STATUS)));
endmodule

// File: rtl/flash_blk_lock.sv
module flash_blk_lock #(
    parameter int ADDR_W    = 24,
    parameter int BLK_SHIFT = 16,
    parameter int SEC_SHIFT = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_nv_i,
    input  logic              cmd_valid_i,
    input  logic [7:0]        cmd_op_i,
    input  logic [ADDR_W-1:0] cmd_addr_i,
    input  logic              wel_i,
    input  logic              pe_req_i,
    input  logic [ADDR_W-1:0] pe_addr_i,
    input  logic              range_prot_i,
    output logic              wel_clr_o,
    output logic              rd_valid_o,
    output logic              rd_locked_o,
    output logic              pe_done_o,
    output logic              pe_grant_o,
    output logic              pe_fail_o,
    output logic              mode_o
);
    localparam int NSEC  = 1 << (BLK_SHIFT - SEC_SHIFT);
    localparam int NBLK  = 1 << (ADDR_W - BLK_SHIFT);
    localparam int NLOCK = NBLK - 2 + 2 * NSEC;
    localparam int IDX_W = $clog2(NLOCK);

    logic [ADDR_W-1:0] addr_q;
    logic [IDX_W-1:0]  idx;
    logic              set_all, clr_all, wr_en, wr_val, lock_bit;

    flk_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_nv_i    (mode_nv_i),
        .cmd_valid_i  (cmd_valid_i),
        .cmd_op_i     (cmd_op_i),
        .cmd_addr_i   (cmd_addr_i),
        .wel_i        (wel_i),
        .pe_req_i     (pe_req_i),
        .pe_addr_i    (pe_addr_i),
        .range_prot_i (range_prot_i),
        .lock_bit_i   (lock_bit),
        .addr_q_o     (addr_q),
        .set_all_o    (set_all),
        .clr_all_o    (clr_all),
        .wr_en_o      (wr_en),
        .wr_val_o     (wr_val),
        .wel_clr_o    (wel_clr_o),
        .rd_valid_o   (rd_valid_o),
        .rd_locked_o  (rd_locked_o),
        .pe_done_o    (pe_done_o),
        .pe_grant_o   (pe_grant_o),
        .pe_fail_o    (pe_fail_o),
        .mode_o       (mode_o)
    );

    flk_addr_map #(
        .ADDR_W    (ADDR_W),
        .BLK_SHIFT (BLK_SHIFT),
        .SEC_SHIFT (SEC_SHIFT),
        .IDX_W     (IDX_W)
    ) map_i (
        .addr (addr_q),
        .idx  (idx)
    );

    flk_lock_bank #(.NLOCK(NLOCK), .IDX_W(IDX_W)) bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_all (set_all),
        .clr_all (clr_all),
        .wr_en   (wr_en),
        .wr_val  (wr_val),
        .idx     (idx),
        .rd_bit  (lock_bit)
    );
endmodule

// File: tb/flash_blk_lock_tb_top.sv
`timescale 1ns/1ps
module flash_blk_lock_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_nv = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_op = '0;
    logic [23:0] cmd_addr = '0;
    logic        wel = 1'b0;
    logic        pe_req = 1'b0;
    logic [23:0] pe_addr = '0;
    logic        rprot = 1'b0;
    logic        wel_clr, rd_valid, rd_locked, pe_done, pe_grant, pe_fail, mode;

    int n_chk = 0;
    int n_bad = 0;
    logic s_clr, s_rdv, s_lck, s_done, s_grant, s_fail;

    always #2 clk = ~clk;

    flash_blk_lock dut_i (
        .clk(clk), .rst_n(rst_n), .mode_nv_i(mode_nv),
        .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_addr_i(cmd_addr),
        .wel_i(wel), .pe_req_i(pe_req), .pe_addr_i(pe_addr), .range_prot_i(rprot),
        .wel_clr_o(wel_clr), .rd_valid_o(rd_valid), .rd_locked_o(rd_locked),
        .pe_done_o(pe_done), .pe_grant_o(pe_grant), .pe_fail_o(pe_fail), .mode_o(mode)
    );

    // op 00h stands for a program/erase check; exp is the fail flag, the
    // lock status or the latch clear, by op.
    typedef struct packed {
        logic [7:0]  op;
        logic [23:0] addr;
        logic        wl;
        logic        rp;
        logic        exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 36;
    localparam vec_t VECS [NV] = '{
        '{8'h00, 24'h123456, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 locks ignored
        '{8'h00, 24'h123456, 1'b0, 1'b1, 1'b1, 4'd2},  // R2
        '{8'h3C, 24'h000000, 1'b0, 1'b0, 1'b1, 4'd1},  // R1 all locked
        '{8'h39, 24'h001000, 1'b1, 1'b0, 1'b0, 4'd9},  // R9 needs scheme
        '{8'h68, 24'h000000, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 needs wel
        '{8'h00, 24'h123456, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 still range
        '{8'h68, 24'h000000, 1'b1, 1'b0, 1'b1, 4'd3},  // R3 select
        '{8'h00, 24'h123456, 1'b0, 1'b0, 1'b1, 4'd4},  // R4
        '{8'h39, 24'h123456, 1'b0, 1'b0, 1'b0, 4'd9},  // R9
        '{8'h3C, 24'h120000, 1'b0, 1'b0, 1'b1, 4'd9},  // R9 unchanged
        '{8'h39, 24'h12ABCD, 1'b1, 1'b0, 1'b1, 4'd6},  // R6
        '{8'h3C, 24'h120000, 1'b0, 1'b0, 1'b0, 4'd6},  // R6
        '{8'h00, 24'h12FFFF, 1'b0, 1'b1, 1'b0, 4'd4},  // R4 range ignored
        '{8'h3C, 24'h130000, 1'b0, 1'b0, 1'b1, 4'd5},  // R5 neighbour
        '{8'h39, 24'h005000, 1'b1, 1'b0, 1'b1, 4'd6},  // R6 bottom sector 5
        '{8'h3C, 24'h005FFF, 1'b0, 1'b0, 1'b0, 4'd5},  // R5
        '{8'h3C, 24'h004FFF, 1'b0, 1'b0, 1'b1, 4'd5},  // R5
        '{8'h3C, 24'h006000, 1'b0, 1'b0, 1'b1, 4'd5},  // R5
        '{8'h39, 24'hFFF123, 1'b1, 1'b0, 1'b1, 4'd6},  // R6 top sector 15
        '{8'h3C, 24'hFFF000, 1'b0, 1'b0, 1'b0, 4'd5},  // R5
        '{8'h3C, 24'hFFE000, 1'b0, 1'b0, 1'b1, 4'd5},  // R5
        '{8'h3C, 24'hFEF000, 1'b0, 1'b0, 1'b1, 4'd5},  // R5 block 254
        '{8'h3C, 24'h01F000, 1'b0, 1'b0, 1'b1, 4'd5},  // R5 block 1
        '{8'h55, 24'h000000, 1'b1, 1'b0, 1'b0, 4'd9},  // R9 unknown op
        '{8'h98, 24'h000000, 1'b1, 1'b0, 1'b1, 4'd7},  // R7
        '{8'h3C, 24'hFE0000, 1'b0, 1'b0, 1'b0, 4'd7},  // R7
        '{8'h3C, 24'h000000, 1'b0, 1'b0, 1'b0, 4'd7},  // R7
        '{8'h00, 24'h800000, 1'b0, 1'b1, 1'b0, 4'd4},  // R4
        '{8'h36, 24'h800000, 1'b1, 1'b0, 1'b1, 4'd6},  // R6
        '{8'h3C, 24'h80FFFF, 1'b0, 1'b0, 1'b1, 4'd6},  // R6
        '{8'h00, 24'h80FFFF, 1'b0, 1'b0, 1'b1, 4'd4},  // R4
        '{8'h3C, 24'h7F0000, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 others kept
        '{8'h7E, 24'h000000, 1'b1, 1'b0, 1'b1, 4'd7},  // R7
        '{8'h3C, 24'hFFF000, 1'b0, 1'b0, 1'b1, 4'd7},  // R7
        '{8'h68, 24'h000000, 1'b1, 1'b0, 1'b1, 4'd3},  // R3 repeat
        '{8'h00, 24'h7F0000, 1'b0, 1'b0, 1'b1, 4'd3}   // R3 stays per-unit
    };

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [7:0] op, input logic [23:0] a, input logic wl,
                          input logic rp, input logic also_pe);
        @(negedge clk);
        cmd_valid = (op != 8'h00);
        cmd_op    = op;
        cmd_addr  = a;
        wel       = wl;
        pe_req    = (op == 8'h00) || also_pe;
        pe_addr   = a;
        rprot     = rp;
        @(negedge clk);
        s_clr = wel_clr; s_rdv = rd_valid; s_lck = rd_locked;
        s_done = pe_done; s_grant = pe_grant; s_fail = pe_fail;
        cmd_valid = 1'b0; pe_req = 1'b0; wel = 1'b0; rprot = 1'b0;
    endtask

    task automatic do_reset(input logic nv);
        @(negedge clk);
        mode_nv = nv;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(mode == 1'b0, "R1 mode", mode, 0);
        check(!pe_done && !rd_valid && !wel_clr, "R1 outputs idle",
              {pe_done, rd_valid, wel_clr}, 0);

        for (int i = 0; i < NV; i++) begin
            run_op(VECS[i].op, VECS[i].addr, VECS[i].wl, VECS[i].rp, 1'b0);
            if (VECS[i].op == 8'h00) begin
                check(s_done && (s_fail == VECS[i].exp) && (s_grant == !VECS[i].exp),
                      $sformatf("R%0d pe row %0d", VECS[i].req, i), s_fail, VECS[i].exp);
            end else if (VECS[i].op == 8'h3C) begin
                // R8 status answer
                check(s_rdv && (s_lck == VECS[i].exp),
                      $sformatf("R%0d status row %0d", VECS[i].req, i), s_lck, VECS[i].exp);
            end else begin
                check(s_clr == VECS[i].exp,
                      $sformatf("R%0d wel_clr row %0d", VECS[i].req, i), s_clr, VECS[i].exp);
            end
        end

        // R10 fail flag lasts one cycle
        @(negedge clk);
        check(!pe_done && !pe_fail && !pe_grant, "R10 one-cycle", {pe_done, pe_fail}, 0);

        // R11 command wins over a same-cycle check
        run_op(8'h3C, 24'h7F0000, 1'b0, 1'b0, 1'b1);
        check(s_rdv && s_lck, "R11 status served", s_lck, 1);
        check(!s_done, "R11 check dropped", s_done, 0);
        @(negedge clk);
        check(!pe_done, "R11 no late answer", pe_done, 0);

        // R1 scheme reload and relock across reset
        run_op(8'h98, 24'h0, 1'b1, 1'b0, 1'b0);
        run_op(8'h3C, 24'h7F0000, 1'b0, 1'b0, 1'b0);
        check(s_rdv && !s_lck, "R7 unlocked before reset", s_lck, 0);
        do_reset(mode);
        check(mode == 1'b1, "R1 mode reloaded", mode, 1);
        run_op(8'h3C, 24'h7F0000, 1'b0, 1'b0, 1'b0);
        check(s_rdv && s_lck, "R1 relocked", s_lck, 1);
        run_op(8'h00, 24'h7F0000, 1'b0, 1'b0, 1'b0);
        check(s_done && s_fail, "R4 after reset", s_fail, 1);

        do_reset(1'b0);
        check(mode == 1'b0, "R1 mode from store", mode, 0);
        run_op(8'h00, 24'h7F0000, 1'b0, 1'b0, 1'b0);
        check(s_done && s_grant && !s_fail, "R2 after reset", s_fail, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule